// File: doc/BRIEF.md
# Rename Table with Result Lifetime Tracking

This block is the register alias table of an out-of-order core whose reorder-buffer slots double as physical registers. Each logical register maps either to the slot of its newest in-flight producer or to the architectural register file. A renamed source comes out as a slot number when its value is still in flight. When it already lives in the architectural file, the source keeps its logical number.

Alongside the mapping, the block tracks the lifetime of every in-flight result. When a logical register receives a newer definition, the slot that held the older definition is marked as superseded. The writeback stage asks about a slot one cycle before it writes that slot's result back. If the slot is already superseded, the result is short-lived and can be parked in a small side buffer instead of the reorder buffer. Each renaming instruction records which slot it superseded, so that its commit can later release that parked value. Every slot is also stamped with the tag of the closest older conditional branch.

Rename requests arrive through a valid/ready handshake. `ren_ready` is low while reset is asserted and high at all other times, so a request transfers in every cycle where `ren_valid` is high outside reset. A cycle without a transfer changes no state. Commit, the short-lived query and the per-slot lookup are plain control pins. The query and the lookup answer combinationally.

Top module: `rename_lifetime_table`

## Requirements
- R1: After reset, every logical register maps to the architectural file, no slot is superseded, no slot holds a flush pointer, every slot tag and the running branch tag are 0, and `ren_ready` is 0 during reset and 1 after it.
- R2: In the same cycle as the request, each source is returned with `in_rob`=1 and the mapped slot number when its mapping is in flight. When the mapping points to the architectural file, `in_rob` is 0 and the index is the logical number zero-extended. Sources read the mapping as it stood before this request's own destination update.
- R3: An accepted request with a destination maps that logical register to the request's slot, located in flight, from the next cycle on.
- R4: An accepted request whose destination was mapped to an in-flight slot marks that older slot as superseded from the next cycle on.
- R5: `qry_short_lived` returns, combinationally in the same cycle, whether the slot on `qry_slot` is superseded.
- R6: An accepted request records in its own slot a flush pointer. The pointer is valid and names the superseded slot when the previous mapping was in flight. It is invalid when the previous mapping was architectural, or when the request has no destination. `look_slot` reads the pointer combinationally.
- R7: Allocating a slot to an accepted request clears that slot's superseded mark.
- R8: Every accepted request stamps its slot with the running 4-bit branch tag, readable on `look_branch_tag`. An accepted request flagged as a conditional branch then advances the running tag by 1, wrapping from 15 to 0.
- R9: A commit of a slot that wrote a destination switches that register's mapping to the architectural file, but only when the mapping still names the committing slot. Otherwise the mapping stays unchanged.
- R10: When a rename and a commit touch the same logical register in one cycle, the rename wins and the register maps to the new slot.
- R11: A request presented with `ren_valid`=0 changes no mapping, mark, pointer or tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Request can be taken (high outside reset) |
| ren_slot | input | 7 | Reorder-buffer slot allocated to the request |
| ren_dst | input | 5 | Destination logical register |
| ren_has_dst | input | 1 | Request writes a destination |
| ren_is_branch | input | 1 | Request is a conditional branch |
| ren_src_a | input | 5 | First source logical register |
| ren_src_b | input | 5 | Second source logical register |
| src_a_in_rob | output | 1 | First source lives in a slot |
| src_a_idx | output | 7 | First source slot or logical number |
| src_b_in_rob | output | 1 | Second source lives in a slot |
| src_b_idx | output | 7 | Second source slot or logical number |
| cmt_valid | input | 1 | A slot commits this cycle |
| cmt_slot | input | 7 | Committing slot |
| qry_slot | input | 7 | Slot about to write back |
| qry_short_lived | output | 1 | Queried slot is already superseded |
| look_slot | input | 7 | Slot whose bookkeeping is read |
| look_flush_valid | output | 1 | Looked-up slot holds a flush pointer |
| look_flush_slot | output | 7 | Slot superseded by the looked-up slot |
| look_branch_tag | output | 4 | Branch tag stamped on the looked-up slot |

## Verification
A stale or wrong map entry shows up at the source outputs of the very next request that reads that register. For example, a missed retire leaves `in_rob` high with an old slot number after its producer has committed. A superseded mark that is lost or not cleared appears on `qry_short_lived` as soon as that slot is queried, which is one cycle after the rename that should have set it. A wrong flush pointer or branch tag is visible on the lookup port one cycle after the slot is allocated. The running branch tag is observed through the stamp on the next slot allocated.

// File: rtl/rt_pkg.sv
package rt_pkg;
  // Where a logical register currently lives.
  typedef enum logic {
    LOC_ROB = 1'b0,
    LOC_ARF = 1'b1
  } loc_e;
endpackage

// File: rtl/rt_map_table.sv
module rt_map_table
  import rt_pkg::*;
#(
  parameter int NL = 32,
  parameter int LW = 5,
  parameter int PW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LW-1:0]    rd_a_lreg,
  input  logic [LW-1:0]    rd_b_lreg,
  output loc_e             rd_a_loc,
  output logic [PW-1:0]    rd_a_idx,
  output loc_e             rd_b_loc,
  output logic [PW-1:0]    rd_b_idx,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_lreg,
  input  logic [PW-1:0]    wr_idx,
  output loc_e             old_loc,
  output logic [PW-1:0]    old_idx,
  input  logic             cmt_en,
  input  logic [LW-1:0]    cmt_lreg,
  input  logic [PW-1:0]    cmt_idx,
  output logic [NL-1:0]    arf_vec,
  output logic [NL*PW-1:0] idx_flat
);
  loc_e          loc_q [NL];
  logic [PW-1:0] idx_q [NL];

  for (genvar g = 0; g < NL; g++) begin : g_entry
    logic hit_wr, hit_cmt;
    assign hit_wr  = wr_en && (wr_lreg == LW'(g));
    assign hit_cmt = cmt_en && (cmt_lreg == LW'(g)) &&
                     (loc_q[g] == LOC_ROB) && (idx_q[g] == cmt_idx);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        loc_q[g] <= LOC_ARF;
        idx_q[g] <= '0;
      end else if (hit_wr) begin
        // a new definition overrides a same-cycle retire
        loc_q[g] <= LOC_ROB;
        idx_q[g] <= wr_idx;
      end else if (hit_cmt) begin
        loc_q[g] <= LOC_ARF;
      end
    end

    assign arf_vec[g]             = (loc_q[g] == LOC_ARF);
    assign idx_flat[g*PW +: PW]   = idx_q[g];
  end

  assign rd_a_loc = loc_q[rd_a_lreg];
  assign rd_a_idx = idx_q[rd_a_lreg];
  assign rd_b_loc = loc_q[rd_b_lreg];
  assign rd_b_idx = idx_q[rd_b_lreg];
  assign old_loc  = loc_q[wr_lreg];
  assign old_idx  = idx_q[wr_lreg];
endmodule

// File: rtl/rt_slot_state.sv
module rt_slot_state #(
  parameter int DEPTH = 96,
  parameter int PW    = 7,
  parameter int LW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [PW-1:0]    alloc_slot,
  input  logic             alloc_has_dst,
  input  logic [LW-1:0]    alloc_dst,
  input  logic             alloc_fp_valid,
  input  logic [PW-1:0]    alloc_fp_slot,
  input  logic             super_en,
  input  logic [PW-1:0]    super_slot,
  input  logic [PW-1:0]    qry_slot,
  output logic             qry_renamed,
  input  logic [PW-1:0]    cmt_slot,
  output logic             cmt_has_dst,
  output logic [LW-1:0]    cmt_dst,
  input  logic [PW-1:0]    look_slot,
  output logic             look_fp_valid,
  output logic [PW-1:0]    look_fp_slot,
  output logic [DEPTH-1:0] renamed_vec,
  output logic [DEPTH-1:0] fp_valid_vec
);
  logic [PW-1:0] fp_q   [DEPTH];
  logic [LW-1:0] dst_q  [DEPTH];
  logic          hasd_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic mine_alloc, mine_super;
    assign mine_alloc = alloc_en && (alloc_slot == PW'(g));
    assign mine_super = super_en && (super_slot == PW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        renamed_vec[g]  <= 1'b0;
        fp_valid_vec[g] <= 1'b0;
        fp_q[g]         <= '0;
        dst_q[g]        <= '0;
        hasd_q[g]       <= 1'b0;
      end else begin
        if (mine_alloc)      renamed_vec[g] <= 1'b0;
        else if (mine_super) renamed_vec[g] <= 1'b1;
        if (mine_alloc) begin
          fp_valid_vec[g] <= alloc_fp_valid;
          fp_q[g]         <= alloc_fp_slot;
          dst_q[g]        <= alloc_dst;
          hasd_q[g]       <= alloc_has_dst;
        end
      end
    end
  end

  always_comb begin
    qry_renamed   = 1'b0;
    cmt_has_dst   = 1'b0;
    cmt_dst       = '0;
    look_fp_valid = 1'b0;
    look_fp_slot  = '0;
    if (int'(qry_slot) < DEPTH)  qry_renamed = renamed_vec[qry_slot];
    if (int'(cmt_slot) < DEPTH) begin
      cmt_has_dst = hasd_q[cmt_slot];
      cmt_dst     = dst_q[cmt_slot];
    end
    if (int'(look_slot) < DEPTH) begin
      look_fp_valid = fp_valid_vec[look_slot];
      look_fp_slot  = fp_q[look_slot];
    end
  end
endmodule

// File: rtl/rt_branch_tagger.sv
module rt_branch_tagger #(
  parameter int DEPTH = 96,
  parameter int PW    = 7,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [PW-1:0]    alloc_slot,
  input  logic             alloc_is_branch,
  input  logic [PW-1:0]    look_slot,
  output logic [TAG_W-1:0] look_tag,
  output logic [TAG_W-1:0] cur_tag
);
  logic [TAG_W-1:0] tag_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)                          cur_tag <= '0;
    else if (alloc_en && alloc_is_branch) cur_tag <= cur_tag + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_tag
    always_ff @(posedge clk) begin
      if (!rst_n)                                    tag_q[g] <= '0;
      else if (alloc_en && alloc_slot == PW'(g))     tag_q[g] <= cur_tag;
    end
  end

  always_comb begin
    look_tag = '0;
    if (int'(look_slot) < DEPTH) look_tag = tag_q[look_slot];
  end
endmodule

// File: rtl/rename_lifetime_table.sv
module rename_lifetime_table
  import rt_pkg::*;
#(
  parameter int NUM_LREGS = 32,
  parameter int ROB_DEPTH = 96,
  parameter int TAG_W     = 4,
  localparam int LW = $clog2(NUM_LREGS),
  localparam int PW = $clog2(ROB_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ren_valid,
  output logic             ren_ready,
  input  logic [PW-1:0]    ren_slot,
  input  logic [LW-1:0]    ren_dst,
  input  logic             ren_has_dst,
  input  logic             ren_is_branch,
  input  logic [LW-1:0]    ren_src_a,
  input  logic [LW-1:0]    ren_src_b,
  output logic             src_a_in_rob,
  output logic [PW-1:0]    src_a_idx,
  output logic             src_b_in_rob,
  output logic [PW-1:0]    src_b_idx,
  input  logic             cmt_valid,
  input  logic [PW-1:0]    cmt_slot,
  input  logic [PW-1:0]    qry_slot,
  output logic             qry_short_lived,
  input  logic [PW-1:0]    look_slot,
  output logic             look_flush_valid,
  output logic [PW-1:0]    look_flush_slot,
  output logic [TAG_W-1:0] look_branch_tag
);
  logic                  ren_fire, wr_en, super_en;
  loc_e                  a_loc, b_loc, old_loc;
  logic [PW-1:0]         a_idx, b_idx, old_idx;
  logic                  cmt_has_dst;
  logic [LW-1:0]         cmt_dst;
  logic [NUM_LREGS-1:0]  map_arf_vec;
  logic [NUM_LREGS*PW-1:0] map_idx_flat;
  logic [ROB_DEPTH-1:0]  renamed_vec, fp_valid_vec;
  logic [TAG_W-1:0]      cur_tag;

  assign ren_ready = rst_n;
  assign ren_fire  = ren_valid & ren_ready;
  assign wr_en     = ren_fire & ren_has_dst;
  assign super_en  = wr_en & (old_loc == LOC_ROB);

  rt_map_table #(.NL(NUM_LREGS), .LW(LW), .PW(PW)) map_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_lreg(ren_src_a), .rd_b_lreg(ren_src_b),
    .rd_a_loc(a_loc), .rd_a_idx(a_idx),
    .rd_b_loc(b_loc), .rd_b_idx(b_idx),
    .wr_en(wr_en), .wr_lreg(ren_dst), .wr_idx(ren_slot),
    .old_loc(old_loc), .old_idx(old_idx),
    .cmt_en(cmt_valid & cmt_has_dst), .cmt_lreg(cmt_dst), .cmt_idx(cmt_slot),
    .arf_vec(map_arf_vec), .idx_flat(map_idx_flat)
  );

  rt_slot_state #(.DEPTH(ROB_DEPTH), .PW(PW), .LW(LW)) slots_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(ren_fire), .alloc_slot(ren_slot),
    .alloc_has_dst(ren_has_dst), .alloc_dst(ren_dst),
    .alloc_fp_valid(super_en), .alloc_fp_slot(old_idx),
    .super_en(super_en), .super_slot(old_idx),
    .qry_slot(qry_slot), .qry_renamed(qry_short_lived),
    .cmt_slot(cmt_slot), .cmt_has_dst(cmt_has_dst), .cmt_dst(cmt_dst),
    .look_slot(look_slot), .look_fp_valid(look_flush_valid),
    .look_fp_slot(look_flush_slot),
    .renamed_vec(renamed_vec), .fp_valid_vec(fp_valid_vec)
  );

  rt_branch_tagger #(.DEPTH(ROB_DEPTH), .PW(PW), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(ren_fire), .alloc_slot(ren_slot),
    .alloc_is_branch(ren_is_branch),
    .look_slot(look_slot), .look_tag(look_branch_tag),
    .cur_tag(cur_tag)
  );

  // Sources: slot number when in flight, logical number otherwise.
  assign src_a_in_rob = (a_loc == LOC_ROB);
  assign src_b_in_rob = (b_loc == LOC_ROB);
  assign src_a_idx    = src_a_in_rob ? a_idx : PW'(ren_src_a);
  assign src_b_idx    = src_b_in_rob ? b_idx : PW'(ren_src_b);
endmodule

// File: rtl/rt_lifetime_chk.sv
module rt_lifetime_chk #(
  parameter int NL    = 32,
  parameter int DEPTH = 96,
  parameter int TAG_W = 4,
  parameter int LW    = 5,
  parameter int PW    = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ren_fire,
  input logic             ren_has_dst,
  input logic             ren_is_branch,
  input logic [PW-1:0]    ren_slot,
  input logic [LW-1:0]    ren_dst,
  input logic             old_in_rob,
  input logic [PW-1:0]    old_idx,
  input logic             cmt_valid,
  input logic [PW-1:0]    cmt_slot,
  input logic             cmt_has_dst,
  input logic [LW-1:0]    cmt_dst,
  input logic [NL-1:0]    map_arf_vec,
  input logic [NL*PW-1:0] map_idx_flat,
  input logic [DEPTH-1:0] renamed_vec,
  input logic [DEPTH-1:0] fp_valid_vec,
  input logic [TAG_W-1:0] cur_tag
);
  logic             p_alloc, p_wdst, p_super, p_self, p_fpv, p_br, p_ret;
  logic [PW-1:0]    p_slot, p_old;
  logic [LW-1:0]    p_dst, p_cdst;
  logic [TAG_W-1:0] p_tag;
  logic             ret_now;

  assign ret_now = cmt_valid && cmt_has_dst && !map_arf_vec[cmt_dst] &&
                   (map_idx_flat[cmt_dst*PW +: PW] == cmt_slot) &&
                   !(ren_fire && ren_has_dst && ren_dst == cmt_dst);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_alloc <= 1'b0; p_wdst <= 1'b0; p_super <= 1'b0; p_self <= 1'b0;
      p_fpv <= 1'b0; p_br <= 1'b0; p_ret <= 1'b0;
      p_slot <= '0; p_old <= '0; p_dst <= '0; p_cdst <= '0; p_tag <= '0;
    end else begin
      p_alloc <= ren_fire;
      p_wdst  <= ren_fire && ren_has_dst;
      p_super <= ren_fire && ren_has_dst && old_in_rob && (old_idx != ren_slot);
      p_self  <= ren_fire && ren_has_dst && old_in_rob && (old_idx == ren_slot);
      p_fpv   <= ren_has_dst && old_in_rob;
      p_br    <= ren_fire && ren_is_branch;
      p_ret   <= ret_now;
      p_slot  <= ren_slot;
      p_old   <= old_idx;
      p_dst   <= ren_dst;
      p_cdst  <= cmt_dst;
      p_tag   <= cur_tag;
    end
  end

  // R3
  a_r3_dst_maps_to_slot: assert property (@(posedge clk) disable iff (!rst_n)
    p_wdst |-> (!map_arf_vec[p_dst] && map_idx_flat[p_dst*PW +: PW] == p_slot));
  // R4
  a_r4_older_slot_marked: assert property (@(posedge clk) disable iff (!rst_n)
    p_super |-> renamed_vec[p_old]);
  // R6
  a_r6_flush_ptr_valid: assert property (@(posedge clk) disable iff (!rst_n)
    p_alloc |-> (fp_valid_vec[p_slot] == p_fpv));
  // R7
  a_r7_realloc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (p_alloc && !p_self) |-> !renamed_vec[p_slot]);
  // R8
  a_r8_tag_advances: assert property (@(posedge clk) disable iff (!rst_n)
    p_br |-> (cur_tag == TAG_W'(p_tag + 1'b1)));
  // R9
  a_r9_retire_to_arf: assert property (@(posedge clk) disable iff (!rst_n)
    p_ret |-> map_arf_vec[p_cdst]);
endmodule

bind rename_lifetime_table rt_lifetime_chk #(
  .NL(NUM_LREGS), .DEPTH(ROB_DEPTH), .TAG_W(TAG_W), .LW(LW), .PW(PW)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .ren_fire(ren_fire), .ren_has_dst(ren_has_dst), .ren_is_branch(ren_is_branch),
  .ren_slot(ren_slot), .ren_dst(ren_dst),
  .old_in_rob(old_loc == rt_pkg::LOC_ROB), .old_idx(old_idx),
  .cmt_valid(cmt_valid), .cmt_slot(cmt_slot),
  .cmt_has_dst(cmt_has_dst), .cmt_dst(cmt_dst),
  .map_arf_vec(map_arf_vec), .map_idx_flat(map_idx_flat),
  .renamed_vec(renamed_vec), .fp_valid_vec(fp_valid_vec),
  .cur_tag(cur_tag)
);

// File: tb/rename_lifetime_table_tb_top.sv
module rename_lifetime_table_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ren_valid = 1'b0;
  logic       ren_ready;
  logic [6:0] ren_slot = '0;
  logic [4:0] ren_dst = '0;
  logic       ren_has_dst = 1'b0;
  logic       ren_is_branch = 1'b0;
  logic [4:0] ren_src_a = '0;
  logic [4:0] ren_src_b = '0;
  logic       src_a_in_rob, src_b_in_rob;
  logic [6:0] src_a_idx, src_b_idx;
  logic       cmt_valid = 1'b0;
  logic [6:0] cmt_slot = '0;
  logic [6:0] qry_slot = '0;
  logic       qry_short_lived;
  logic [6:0] look_slot = '0;
  logic       look_flush_valid;
  logic [6:0] look_flush_slot;
  logic [3:0] look_branch_tag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  rename_lifetime_table dut_i (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_slot(ren_slot), .ren_dst(ren_dst), .ren_has_dst(ren_has_dst),
    .ren_is_branch(ren_is_branch), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
    .src_a_in_rob(src_a_in_rob), .src_a_idx(src_a_idx),
    .src_b_in_rob(src_b_in_rob), .src_b_idx(src_b_idx),
    .cmt_valid(cmt_valid), .cmt_slot(cmt_slot),
    .qry_slot(qry_slot), .qry_short_lived(qry_short_lived),
    .look_slot(look_slot), .look_flush_valid(look_flush_valid),
    .look_flush_slot(look_flush_slot), .look_branch_tag(look_branch_tag)
  );

  // slot dst hd br srcA srcB | expA(rob,idx) expB(rob,idx) tag fpv fp
  localparam logic [51:0] VEC [5] = '{
    {7'd0, 5'd1, 1'b1, 1'b0, 5'd2, 5'd3, 1'b0, 7'd2, 1'b0, 7'd3, 4'd0, 1'b0, 7'd0},
    {7'd1, 5'd5, 1'b1, 1'b0, 5'd1, 5'd3, 1'b1, 7'd0, 1'b0, 7'd3, 4'd0, 1'b0, 7'd0},
    {7'd2, 5'd1, 1'b1, 1'b0, 5'd5, 5'd4, 1'b1, 7'd1, 1'b0, 7'd4, 4'd0, 1'b1, 7'd0},
    {7'd3, 5'd0, 1'b0, 1'b1, 5'd1, 5'd5, 1'b1, 7'd2, 1'b1, 7'd1, 4'd0, 1'b0, 7'd0},
    {7'd4, 5'd5, 1'b1, 1'b0, 5'd5, 5'd0, 1'b1, 7'd1, 1'b0, 7'd0, 4'd1, 1'b1, 7'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Present a request at the falling edge; outputs settle 1 ns later.
  task automatic present(input logic v, input logic [6:0] s, input logic [4:0] d,
                         input logic hd, input logic br,
                         input logic [4:0] a, input logic [4:0] b);
    @(negedge clk);
    ren_valid = v; ren_slot = s; ren_dst = d; ren_has_dst = hd;
    ren_is_branch = br; ren_src_a = a; ren_src_b = b;
    #1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    ren_valid = 1'b0;
    cmt_valid = 1'b0;
  endtask

  task automatic src_a_of(input logic [4:0] r, input string req,
                          input int exp_rob, input int exp_idx);
    present(1'b0, 7'd127, 5'd0, 1'b0, 1'b0, r, 5'd0);
    chk({req, " src in_rob"}, src_a_in_rob, exp_rob);
    chk({req, " src idx"}, src_a_idx, exp_idx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

  initial begin
    // R1: ready low in reset, reset state afterwards
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready in reset", ren_ready, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 ready after reset", ren_ready, 1);
    src_a_of(5'd9, "R1", 0, 9);
    qry_slot = 7'd5; look_slot = 7'd0; #1;
    chk("R1 not superseded", qry_short_lived, 0);
    chk("R1 no flush ptr", look_flush_valid, 0);
    chk("R1 tag zero", look_branch_tag, 0);

    // R2 R3 R4 R6 R8: vector walk
    for (int i = 0; i < 5; i++) begin
      logic [51:0] v;
      v = VEC[i];
      present(1'b1, v[51:45], v[44:40], v[39], v[38], v[37:33], v[32:28]);
      chk($sformatf("R2 op%0d a_rob", i), src_a_in_rob, v[27]);
      chk($sformatf("R2 op%0d a_idx", i), src_a_idx, v[26:20]);
      chk($sformatf("R2 op%0d b_rob", i), src_b_in_rob, v[19]);
      chk($sformatf("R2 op%0d b_idx", i), src_b_idx, v[18:12]);
      step();
      @(negedge clk);
      look_slot = v[51:45];
      #1;
      chk($sformatf("R8 op%0d tag", i), look_branch_tag, v[11:8]);
      chk($sformatf("R6 op%0d fp valid", i), look_flush_valid, v[7]);
      if (v[7]) chk($sformatf("R6 op%0d fp slot", i), look_flush_slot, v[6:0]);
    end
    // R3: r1 -> slot 2, r5 -> slot 4
    src_a_of(5'd1, "R3 r1", 1, 2);
    src_a_of(5'd5, "R3 r5", 1, 4);

    // R4 R5: superseded slots 0 and 1; 2,3,4 still live (same-cycle query)
    qry_slot = 7'd0; #1; chk("R5 q0", qry_short_lived, 1);
    qry_slot = 7'd1; #1; chk("R4 q1", qry_short_lived, 1);
    qry_slot = 7'd2; #1; chk("R4 q2", qry_short_lived, 0);
    qry_slot = 7'd3; #1; chk("R4 q3", qry_short_lived, 0);
    qry_slot = 7'd4; #1; chk("R5 q4", qry_short_lived, 0);

    // R11: valid low must not update r2
    present(1'b0, 7'd10, 5'd2, 1'b1, 1'b1, 5'd0, 5'd0);
    step();
    src_a_of(5'd2, "R11 r2", 0, 2);
    look_slot = 7'd10; #1;
    chk("R11 tag untouched", look_branch_tag, 0);

    // R9: commit of superseded slot 0 leaves r1 on slot 2
    @(negedge clk); cmt_valid = 1'b1; cmt_slot = 7'd0;
    step();
    src_a_of(5'd1, "R9 stale commit", 1, 2);
    @(negedge clk); cmt_valid = 1'b1; cmt_slot = 7'd2;
    step();
    src_a_of(5'd1, "R9 retire", 0, 1);

    // R6: r1 now architectural -> no flush pointer
    present(1'b1, 7'd5, 5'd1, 1'b1, 1'b0, 5'd0, 5'd0);
    step();
    @(negedge clk); look_slot = 7'd5; #1;
    chk("R6 arf prev no ptr", look_flush_valid, 0);

    // R10: rename r5 to slot 23 while slot 4 (r5) commits
    present(1'b1, 7'd23, 5'd5, 1'b1, 1'b0, 5'd0, 5'd0);
    cmt_valid = 1'b1; cmt_slot = 7'd4;
    step();
    src_a_of(5'd5, "R10 rename wins", 1, 23);

    // R7: reallocating superseded slot 0 clears its mark
    present(1'b1, 7'd0, 5'd7, 1'b1, 1'b0, 5'd0, 5'd0);
    step();
    @(negedge clk); qry_slot = 7'd0; #1;
    chk("R7 realloc clears", qry_short_lived, 0);

    // R8: 16 branches wrap the running tag
    for (int k = 0; k < 16; k++) begin
      present(1'b1, 7'(6 + k), 5'd0, 1'b0, 1'b1, 5'd0, 5'd0);
      step();
    end
    present(1'b1, 7'd22, 5'd0, 1'b0, 1'b0, 5'd0, 5'd0);
    step();
    @(negedge clk); look_slot = 7'd20; #1;
    chk("R8 tag 15", look_branch_tag, 15);
    look_slot = 7'd21; #1;
    chk("R8 wrap to 0", look_branch_tag, 0);
    look_slot = 7'd22; #1;
    chk("R8 after wrap", look_branch_tag, 1);

    report();
  end
endmodule